// File: doc/BRIEF.md
# DAC Configuration Word Capture and Power-Mode Controller

This block sits beside a dual current-output converter and owns its configuration. Software or a host device puts an 8-bit word on the upper eight lines of the channel-A data bus and pulses an active-low write strobe. The word is taken on the strobe's rising edge. The strobe has no fixed phase relation to the conversion clock, and that clock keeps running during a write. A toggle flag and a two-flop synchronizer carry the event into the conversion clock domain. There every decoded field changes together on one clock edge.

The word selects one of three power states: normal, standby or power-down. It also selects the interleaved input mode, the reference source and a 4-bit trim for the channel-A gain. When the converter returns to normal operation, a wake-up timer holds the ready output low for a delay that depends on how deep the converter slept. The delays are given in microseconds and are converted to cycles from a clock-frequency parameter. After reset the block is in normal operation, ready is high, and all other fields hold their defaults.

Top module: `dac_cfg_ctrl`

## Requirements
- R1: `cw_bus` carries the word with this bit assignment: bit 7 = power-down request, bit 6 = converter enable, bit 5 = interleave select, bit 4 = reference select, bits 3..0 = gain trim (bit 3 most significant).
- R2: The word is captured on the rising edge of `wr_n`. All outputs that come from it change together on the third rising edge of `clk` after that strobe edge. They do not change on any other edge.
- R3: Bit 7 = 1 selects power-down whatever bit 6 holds. Bit 7 = 0 with bit 6 = 0 selects standby. Bit 7 = 0 with bit 6 = 1 selects normal. Exactly one of the three mode outputs is high at all times.
- R4: `ilv_en` follows bit 5. `ext_ref` follows bit 4, where 1 selects the external reference and 0 the internal one.
- R5: `gain_code` follows bits 3..0. Code 4'b1000 is the nominal (0 dB) trim.
- R6: During reset and after it, the state is: normal mode, `ilv_en`=0, `ext_ref`=0, `gain_code`=4'b1000, `ready`=1.
- R7: On entry to normal mode from standby, `ready` is low on the entry edge and stays low until exactly STBY_WAKE_US*CLK_MHZ cycles after that edge. It then goes high. `ready` is never high outside normal mode.
- R8: On entry to normal mode from power-down, the delay is PD_WAKE_US*CLK_MHZ cycles.
- R9: Once power-down has been entered, the long delay applies to the next wake-up even if standby was selected in between. The short delay is used again only after a wake-up has completed.
- R10: Leaving normal mode drops `ready` on the mode-change edge and cancels a wake-up in progress. A later entry restarts the full delay. A new word that keeps normal mode leaves `ready` as it was.
- R11: Changes on `cw_bus` that are not followed by a rising edge of `wr_n` change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset, `clk` domain |
| wr_n | input | 1 | Active-low write strobe, asynchronous; word taken on its rising edge |
| cw_bus | input | 8 | Upper eight lines of the channel-A data bus |
| mode_normal | output | 1 | Normal operation selected |
| mode_standby | output | 1 | Standby selected |
| mode_down | output | 1 | Power-down selected |
| ilv_en | output | 1 | Interleaved input mode enabled |
| ext_ref | output | 1 | External reference selected |
| gain_code | output | 4 | Channel-A gain trim code |
| ready | output | 1 | Converter output valid (normal mode, wake-up delay over) |

## Verification
Some properties hold on every cycle, and the assertions check them continuously. Exactly one power state is active. `ready` never shows outside normal mode, and it is low on the edge where normal mode is entered. No decoded field moves except on a synchronized update edge. Other behaviour needs the bench's scenarios: the exact cycle a strobe lands, the lengths of the short and long wake-up delays, the deep-sleep memory across an intervening standby, a cancelled wake-up, and the absence of any effect from bus activity without a strobe edge.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;

  typedef struct packed {
    logic       pd;
    logic       dac_en;
    logic       ilv;
    logic       ext_ref;
    logic [3:0] gain;
  } cfg_word_t;

  localparam int CFG_W = $bits(cfg_word_t);

  localparam cfg_word_t CFG_DEFAULT = '{pd: 1'b0, dac_en: 1'b1, ilv: 1'b0,
                                        ext_ref: 1'b0, gain: 4'b1000};

  typedef enum logic [1:0] {
    PWR_NORMAL  = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_DOWN    = 2'd2
  } pwr_state_e;

  // power-down request outranks the enable bit
  function automatic pwr_state_e decode_pwr(cfg_word_t w);
    if (w.pd)          return PWR_DOWN;
    else if (!w.dac_en) return PWR_STANDBY;
    else               return PWR_NORMAL;
  endfunction

endpackage

// File: rtl/cfg_word_cdc.sv
module cfg_word_cdc #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         upd
);
  localparam int TOP = SYNC_STAGES - 1;

  // strobe domain: word holder and event toggle
  logic [W-1:0] hold_q = '0;
  logic         tgl_q  = 1'b0;

  always_ff @(posedge wr_n) begin
    hold_q <= din;
    tgl_q  <= ~tgl_q;
  end

  // clock domain: synchronizer chain and edge memory
  logic [SYNC_STAGES-1:0] sync_q = '0;
  logic                   seen_q = 1'b0;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[TOP-1:0], tgl_q};
    seen_q <= sync_q[TOP];
  end

  assign upd  = !rst && (sync_q[TOP] != seen_q);
  assign dout = hold_q;

endmodule

// File: rtl/cfg_wake_timer.sv
module cfg_wake_timer #(
  parameter int SHORT_CYC = 750,
  parameter int LONG_CYC  = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  input  logic clear,
  output logic busy
);
  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (start)
      cnt_q <= long_sel ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/dac_cfg_ctrl.sv
module dac_cfg_ctrl #(
  parameter int CLK_MHZ      = 250,
  parameter int STBY_WAKE_US = 3,
  parameter int PD_WAKE_US   = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_n,
  input  logic [7:0] cw_bus,
  output logic       mode_normal,
  output logic       mode_standby,
  output logic       mode_down,
  output logic       ilv_en,
  output logic       ext_ref,
  output logic [3:0] gain_code,
  output logic       ready
);
  import dac_cfg_pkg::*;

  localparam int STBY_CYC = CLK_MHZ * STBY_WAKE_US;
  localparam int PD_CYC   = CLK_MHZ * PD_WAKE_US;

  logic [CFG_W-1:0] cdc_word;
  logic             cfg_upd;

  cfg_word_cdc #(.W(CFG_W), .SYNC_STAGES(2)) u_cdc (
    .clk  (clk),
    .rst  (rst),
    .wr_n (wr_n),
    .din  (cw_bus),
    .dout (cdc_word),
    .upd  (cfg_upd)
  );

  cfg_word_t  cfg_q, new_cfg;
  pwr_state_e state_q, new_state;
  logic       cold_q;
  logic       wake_busy;
  logic       enter_norm, leave_norm, enter_down;

  assign new_cfg    = cfg_word_t'(cdc_word);
  assign new_state  = decode_pwr(new_cfg);
  assign enter_norm = cfg_upd && (new_state == PWR_NORMAL) && (state_q != PWR_NORMAL);
  assign leave_norm = cfg_upd && (new_state != PWR_NORMAL);
  assign enter_down = cfg_upd && (new_state == PWR_DOWN);

  cfg_wake_timer #(.SHORT_CYC(STBY_CYC), .LONG_CYC(PD_CYC)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .start    (enter_norm),
    .long_sel (cold_q),
    .clear    (leave_norm),
    .busy     (wake_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_DEFAULT;
      state_q <= PWR_NORMAL;
      cold_q  <= 1'b0;
    end else begin
      if (cfg_upd) begin
        cfg_q   <= new_cfg;
        state_q <= new_state;
      end
      // deep-sleep memory lasts until a wake-up completes
      if (enter_down)
        cold_q <= 1'b1;
      else if (ready)
        cold_q <= 1'b0;
    end
  end

  assign mode_normal  = (state_q == PWR_NORMAL);
  assign mode_standby = (state_q == PWR_STANDBY);
  assign mode_down    = (state_q == PWR_DOWN);
  assign ilv_en       = cfg_q.ilv;
  assign ext_ref      = cfg_q.ext_ref;
  assign gain_code    = cfg_q.gain;
  assign ready        = mode_normal && !wake_busy;

endmodule

// File: rtl/dac_cfg_ctrl_chk.sv
module dac_cfg_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       upd,
  input logic       mode_normal,
  input logic       mode_standby,
  input logic       mode_down,
  input logic       ilv_en,
  input logic       ext_ref,
  input logic [3:0] gain_code,
  input logic       ready
);

  assert_one_mode_R3: assert property (@(posedge clk) disable iff (rst)
    $countones({mode_normal, mode_standby, mode_down}) == 1);

  assert_ready_in_normal_R7: assert property (@(posedge clk) disable iff (rst)
    ready |-> mode_normal);

  assert_atomic_update_R2: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable({mode_normal, mode_standby, mode_down, ilv_en, ext_ref, gain_code}));

  assert_entry_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_normal) |-> !ready);

  assert_leave_drops_ready_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_normal) |-> !ready);

endmodule

bind dac_cfg_ctrl dac_cfg_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .upd          (cfg_upd),
  .mode_normal  (mode_normal),
  .mode_standby (mode_standby),
  .mode_down    (mode_down),
  .ilv_en       (ilv_en),
  .ext_ref      (ext_ref),
  .gain_code    (gain_code),
  .ready        (ready)
);

// File: tb/dac_cfg_ctrl_test.sv
`timescale 1ns/1ps
module dac_cfg_ctrl_test;
  localparam int CLK_MHZ = 250;
  localparam int SB_US   = 3;
  localparam int PD_US   = 20;
  localparam int STBY_N  = CLK_MHZ * SB_US;
  localparam int PD_N    = CLK_MHZ * PD_US;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] cw_bus = '0;
  logic       mode_normal, mode_standby, mode_down, ilv_en, ext_ref, ready;
  logic [3:0] gain_code;

  dac_cfg_ctrl #(.CLK_MHZ(CLK_MHZ), .STBY_WAKE_US(SB_US), .PD_WAKE_US(PD_US)) uut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .cw_bus(cw_bus),
    .mode_normal(mode_normal), .mode_standby(mode_standby), .mode_down(mode_down),
    .ilv_en(ilv_en), .ext_ref(ext_ref), .gain_code(gain_code), .ready(ready)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  typedef struct {
    int         cyc;
    logic [9:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  // expected outputs {down, standby, normal, ilv, ext, gain, ready} from R1/R3/R4/R5
  function automatic logic [9:0] model(logic [7:0] w, logic rdy);
    logic pd, en;
    pd = w[7];
    en = w[6];
    return {pd, !pd && !en, !pd && en, w[5], w[4], w[3:0], rdy};
  endfunction

  task automatic expect_at(int c, logic [9:0] e, string tag);
    sbq.push_back('{c, e, tag});
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // returns the cycle count at the strobe's rising edge
  task automatic write_cfg(logic [7:0] w, output int r);
    @(negedge clk);
    wr_n   = 1'b0;
    cw_bus = ~w;
    @(negedge clk);
    cw_bus = w;
    @(negedge clk);
    wr_n = 1'b1;
    r    = cyc;
    #3 cw_bus = 8'hA5;
  endtask

  // monitor: scoreboard compare
  logic [9:0] obs;
  item_t      it;
  always @(negedge clk) begin
    obs = {mode_down, mode_standby, mode_normal, ilv_en, ext_ref, gain_code, ready};
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      it = sbq.pop_front();
      checks++;
      if (it.cyc != cyc || obs !== it.exp) begin
        errs++;
        $display("FAIL %s: cycle %0d got %b expected %b", it.tag, cyc, obs, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    int r, r2, t;
    logic [7:0] last;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    expect_at(cyc + 1, model(8'h48, 1'b1), "R6 reset defaults");
    wait_to(cyc + 2);

    // R1 R4 R5: field positions; R2 timing; R10 rewrite in normal keeps ready
    write_cfg(8'b0111_0110, r);
    expect_at(r + 2, model(8'h48, 1'b1), "R2 no early update");
    expect_at(r + 3, model(8'b0111_0110, 1'b1), "R1 R4 R5 R10 fields, ready kept");
    wait_to(r + 4);
    last = 8'b0111_0110;

    // R11: bus activity with strobe high, then strobe held low without rise
    t = cyc;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cw_bus = 8'(i * 37 + 11);
    end
    expect_at(cyc + 1, model(last, 1'b1), "R11 bus toggling, strobe high");
    wait_to(cyc + 2);
    @(negedge clk);
    wr_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cw_bus = 8'(i * 53 + 7);
    end
    expect_at(cyc + 1, model(last, 1'b1), "R11 bus toggling, strobe low");
    wait_to(cyc + 2);
    @(negedge clk);
    cw_bus = last;
    @(negedge clk);
    wr_n = 1'b1;
    wait_to(cyc + 5);

    // R3 standby; R10 ready drops
    write_cfg(8'b0011_1000, r);
    expect_at(r + 3, model(8'b0011_1000, 1'b0), "R3 R10 standby, ready low");
    wait_to(r + 4);

    // R7 short wake
    write_cfg(8'b0100_0101, r);
    expect_at(r + 3, model(8'b0100_0101, 1'b0), "R7 entry edge not ready");
    expect_at(r + 2 + STBY_N, model(8'b0100_0101, 1'b0), "R7 last waiting cycle");
    expect_at(r + 3 + STBY_N, model(8'b0100_0101, 1'b1), "R7 short wake done");
    wait_to(r + 4 + STBY_N);

    // R3 power-down wins over enable bit
    write_cfg(8'b1100_1111, r);
    expect_at(r + 3, model(8'b1100_1111, 1'b0), "R3 power-down with enable set");
    wait_to(r + 4);

    // R8 long wake
    write_cfg(8'b0100_1000, r);
    expect_at(r + 2 + STBY_N, model(8'b0100_1000, 1'b0), "R8 still low past short delay");
    expect_at(r + 2 + PD_N, model(8'b0100_1000, 1'b0), "R8 last waiting cycle");
    expect_at(r + 3 + PD_N, model(8'b0100_1000, 1'b1), "R8 long wake done");
    wait_to(r + 4 + PD_N);

    // R9 power-down, standby, then normal: long delay still applies
    write_cfg(8'b1000_0000, r);
    expect_at(r + 3, model(8'b1000_0000, 1'b0), "R3 power-down, enable clear");
    wait_to(r + 4);
    write_cfg(8'b0000_1000, r);
    expect_at(r + 3, model(8'b0000_1000, 1'b0), "R9 standby after power-down");
    wait_to(r + 4);
    write_cfg(8'b0100_1000, r);
    expect_at(r + 3 + STBY_N, model(8'b0100_1000, 1'b0), "R9 no short wake after deep sleep");
    expect_at(r + 2 + PD_N, model(8'b0100_1000, 1'b0), "R9 last waiting cycle");
    expect_at(r + 3 + PD_N, model(8'b0100_1000, 1'b1), "R9 long wake done");
    wait_to(r + 4 + PD_N);

    // R10 cancel a wake-up and restart
    write_cfg(8'b0000_0011, r);
    wait_to(r + 4);
    write_cfg(8'b0100_0011, r);
    wait_to(r + 100);
    write_cfg(8'b0001_0011, r2);
    expect_at(r2 + 3, model(8'b0001_0011, 1'b0), "R10 wake cancelled");
    wait_to(r2 + 4);
    write_cfg(8'b0100_0011, r);
    expect_at(r + 2 + STBY_N, model(8'b0100_0011, 1'b0), "R10 full delay restarted");
    expect_at(r + 3 + STBY_N, model(8'b0100_0011, 1'b1), "R10 restarted wake done");
    wait_to(r + 5 + STBY_N);

    if (sbq.size() != 0) begin
      checks++;
      errs++;
      $display("FAIL scoreboard R2: got %0d pending expected 0", sbq.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule